// File: doc/BRIEF.md
# Two-Channel DMA Transfer Controller

This block moves bytes on its own across an 8-bit processor bus. The bus has a 20-bit memory space and a 16-bit I/O space. There are two independent channels. Each channel holds a source address, a destination address, a 16-bit byte count and a control word. The control word chooses memory or I/O for each side and how each address steps. It also sets how the transfer is paced: by the channel's active-low request line, as one uninterrupted burst, or one byte per bus tenure so that the processor gets the bus back between bytes. The request line of each channel can be sensed by level or by falling edge.

When a channel has work, the block raises a bus request and waits for the grant. It then runs one read cycle at the source and, in the next clock, one write cycle at the destination that carries the byte just read. When the last byte has been written, the channel disarms itself and pulses its done line for one clock. Software sets up a channel through a simple write port, one field per write. The bus cycles here take one clock each; wait states are handled outside the block.

Top module: `dma_xfer_ctrl`

## Requirements
- R1: While `rst_n` is low and after reset, `bus_req`, `bus_rd`, `bus_wr` and `done` are all low.
- R2: Every byte moves as a one-clock cycle with `bus_rd` high at the source, followed in the very next clock by a one-clock cycle with `bus_wr` high at the destination. `bus_wdata` equals the `bus_rdata` sampled in the read cycle. `bus_rd` and `bus_wr` are never high together.
- R3: A memory-side address is 20 bits wide. After each byte it changes according to its 2-bit step field: 00 adds one, 01 subtracts one, 10 and 11 leave it unchanged. A carry or borrow passes between bit 15 and bit 16, so a block can cross a 64 KB boundary.
- R4: When a side is marked as I/O, its cycles drive `bus_io` high and put the low 16 bits of its address register on `bus_addr[15:0]`, with `bus_addr[19:16]` at zero. Memory cycles drive `bus_io` low.
- R5: A count of N (1 to 65535) moves exactly N bytes, and a count of 0 moves 65536 bytes. One clock after the final write cycle, the channel's bit of `done` is high for exactly one clock, and the channel's enable bit is cleared.
- R6: Request pacing with level sensing (pace 00, edge bit 0): the channel asks for the bus only while its `dreq_n` is low. After each byte it keeps the bus and goes on to the next byte if `dreq_n` is still low in the write cycle. Otherwise it releases the bus.
- R7: Request pacing with edge sensing (pace 00, edge bit 1): each falling edge of `dreq_n` seen while the channel is enabled allows exactly one byte. Holding `dreq_n` low does not allow more.
- R8: Burst pacing (pace 01) ignores `dreq_n` and moves the whole block in a single bus tenure, with `bus_req` held high throughout.
- R9: Cycle-steal pacing (pace 10) ignores `dreq_n`, moves one byte per tenure, and drops `bus_req` for at least one clock between bytes.
- R10: When both channels are ready while the block is idle, channel 0 is served first. A channel keeps the bus for its whole tenure.
- R11: `bus_req` stays high while the block waits for `bus_gnt`. No read or write cycle happens until `bus_gnt` is high.
- R12: Register writes use `cfg_we`, `cfg_ch` and `cfg_sel`. The `cfg_sel` codes are 0 for source address, 1 for destination address, 2 for count (low 16 bits of `cfg_wdata`) and 3 for control. The control bits are: 0 enable, 2:1 pace, 3 edge sense, 5:4 source step, 7:6 destination step, 8 source is I/O, 9 destination is I/O. A channel with enable 0 never requests the bus. A control write clears any falling edge that has been seen but not yet served.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_ch | input | 1 | Channel selected by the write |
| cfg_sel | input | 2 | Register selected by the write |
| cfg_wdata | input | 20 | Write data |
| dreq_n | input | 2 | Active-low transfer request, one bit per channel |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant |
| bus_rd | output | 1 | Read cycle strobe |
| bus_wr | output | 1 | Write cycle strobe |
| bus_io | output | 1 | High for an I/O cycle, low for a memory cycle |
| bus_addr | output | 20 | Cycle address |
| bus_rdata | input | 8 | Read data, sampled in the read cycle |
| bus_wdata | output | 8 | Write data |
| done | output | 2 | One-clock end-of-block pulse per channel |

## Verification
The bench runs a burst block whose source counts up and whose destination counts down across a 64 KB boundary. This separates a correct carry and borrow into bits 19:16 from a plain 16-bit wrap. Cycle-steal and burst blocks with the same grant latency are told apart by the number of bus tenures. A level-sensed request held high and then low shows that a quiet line blocks the channel and that a held line keeps the bus. An edge-sensed request held low for many clocks must yield only one byte. Channels armed together and released by the same request edge show the priority order. A block of count zero must produce exactly 65536 write cycles and one done pulse.

// File: rtl/dma_xfer_pkg.sv
// Shared encodings for the two-channel DMA transfer controller.
// Assumes: control word field positions are fixed by the register write port.
package dma_xfer_pkg;
    localparam int CTL_W    = 10;
    localparam int CB_EN    = 0;
    localparam int CB_PACE  = 1;
    localparam int CB_EDGE  = 3;
    localparam int CB_SSTEP = 4;
    localparam int CB_DSTEP = 6;
    localparam int CB_SIO   = 8;
    localparam int CB_DIO   = 9;

    localparam logic [1:0] SEL_SRC = 2'd0;
    localparam logic [1:0] SEL_DST = 2'd1;
    localparam logic [1:0] SEL_CNT = 2'd2;
    localparam logic [1:0] SEL_CTL = 2'd3;

    localparam logic [1:0] STEP_UP   = 2'd0;
    localparam logic [1:0] STEP_DOWN = 2'd1;

    typedef enum logic [1:0] {
        PACE_REQ     = 2'd0,
        PACE_BURST   = 2'd1,
        PACE_STEAL   = 2'd2,
        PACE_REQ_ALT = 2'd3
    } pace_e;

    typedef enum logic [1:0] {
        ENG_IDLE     = 2'd0,
        ENG_WAIT_GNT = 2'd1,
        ENG_READ     = 2'd2,
        ENG_WRITE    = 2'd3
    } eng_st_e;
endpackage

// File: rtl/dma_xfer_chan.sv
// One DMA channel: holds the address, count and control registers, senses the
// request line by level or falling edge, and steps its addresses after each byte.
// Assumes: dreq_n is already synchronous to clk; software does not write a
// channel while it is moving a byte (a write would win over the step).
module dma_xfer_chan
    import dma_xfer_pkg::*;
#(
    parameter int AW  = 20,
    parameter int IOW = 16,
    parameter int CW  = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_sel,
    input  logic [AW-1:0] cfg_wdata,
    input  logic          dreq_n,
    input  logic          adv,
    output logic          pend,
    output logic          cont,
    output logic          last,
    output logic          done,
    output pace_e         pace,
    output logic [AW-1:0] src_bus,
    output logic [AW-1:0] dst_bus,
    output logic          src_io,
    output logic          dst_io
);
    localparam int HI_W = AW - IOW;

    logic [AW-1:0]    src_q;
    logic [AW-1:0]    dst_q;
    logic [CW-1:0]    cnt_q;
    logic [CTL_W-1:0] ctl_q;
    logic             flag_q;
    logic             prev_q;
    logic             done_q;
    logic             en;
    logic             edge_sense;
    logic             edge_now;
    logic             level_on;
    logic             req_ok;
    logic             ctl_wr;

    function automatic logic [AW-1:0] stepped(input logic [AW-1:0] a, input logic [1:0] s);
        case (s)
            STEP_UP:   return a + AW'(1);
            STEP_DOWN: return a - AW'(1);
            default:   return a;
        endcase
    endfunction

    function automatic logic [AW-1:0] to_bus(input logic [AW-1:0] a, input logic io);
        return io ? {{HI_W{1'b0}}, a[IOW-1:0]} : a;
    endfunction

    // Decode control fields and request conditions.
    always_comb begin
        en         = ctl_q[CB_EN];
        edge_sense = ctl_q[CB_EDGE];
        pace       = pace_e'(ctl_q[CB_PACE +: 2]);
        src_io     = ctl_q[CB_SIO];
        dst_io     = ctl_q[CB_DIO];
        level_on   = ~dreq_n;
        edge_now   = prev_q & ~dreq_n;
        req_ok     = edge_sense ? flag_q : level_on;
        pend       = en & ((pace == PACE_BURST) | (pace == PACE_STEAL) | req_ok);
        cont       = edge_sense ? edge_now : level_on;
        last       = (cnt_q == CW'(1));
        ctl_wr     = cfg_we & (cfg_sel == SEL_CTL);
        src_bus    = to_bus(src_q, ctl_q[CB_SIO]);
        dst_bus    = to_bus(dst_q, ctl_q[CB_DIO]);
        done       = done_q;
    end

    // Register file: software writes win, else step after each written byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q <= '0;
            dst_q <= '0;
            cnt_q <= '0;
            ctl_q <= '0;
        end else if (cfg_we) begin
            case (cfg_sel)
                SEL_SRC: src_q <= cfg_wdata;
                SEL_DST: dst_q <= cfg_wdata;
                SEL_CNT: cnt_q <= cfg_wdata[CW-1:0];
                default: ctl_q <= cfg_wdata[CTL_W-1:0];
            endcase
        end else if (adv) begin
            src_q <= stepped(src_q, ctl_q[CB_SSTEP +: 2]);
            dst_q <= stepped(dst_q, ctl_q[CB_DSTEP +: 2]);
            cnt_q <= cnt_q - CW'(1);
            if (last) begin
                ctl_q[CB_EN] <= 1'b0;
            end
        end
    end

    // Remember the previous request level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b1;
        end else begin
            prev_q <= dreq_n;
        end
    end

    // Pending-edge flag: set by a falling edge, consumed by a byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (ctl_wr) begin
            flag_q <= 1'b0;
        end else if (en && edge_now) begin
            flag_q <= 1'b1;
        end else if (adv) begin
            flag_q <= 1'b0;
        end
    end

    // One-clock end-of-block pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else begin
            done_q <= adv & last;
        end
    end
endmodule

// File: rtl/dma_xfer_pick.sv
// Fixed-priority selector: the lowest-numbered ready channel wins.
// Assumes: NCH >= 1.
module dma_xfer_pick #(
    parameter int NCH = 2,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic [NCH-1:0] ready,
    output logic           any,
    output logic [CHW-1:0] idx
);
    // Scan from the highest index down so the lowest ready one is left.
    always_comb begin
        any = |ready;
        idx = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (ready[i]) begin
                idx = CHW'(i);
            end
        end
    end
endmodule

// File: rtl/dma_xfer_engine.sv
// Bus sequencer: requests the bus, waits for the grant, then runs a read cycle
// and a write cycle per byte, choosing after each write whether to go on.
// Assumes: bus_gnt stays high while bus_req is high once given; one-clock cycles.
module dma_xfer_engine
    import dma_xfer_pkg::*;
#(
    parameter int NCH = 2,
    parameter int AW  = 20,
    parameter int DW  = 8,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           pend_any,
    input  logic [CHW-1:0] pick,
    input  pace_e          pace_s,
    input  logic           last_s,
    input  logic           cont_s,
    input  logic [AW-1:0]  src_s,
    input  logic [AW-1:0]  dst_s,
    input  logic           src_io_s,
    input  logic           dst_io_s,
    input  logic           bus_gnt,
    input  logic [DW-1:0]  bus_rdata,
    output logic [CHW-1:0] cur,
    output logic           beat,
    output logic           bus_req,
    output logic           bus_rd,
    output logic           bus_wr,
    output logic           bus_io,
    output logic [AW-1:0]  bus_addr,
    output logic [DW-1:0]  bus_wdata
);
    eng_st_e        st_q;
    logic [CHW-1:0] cur_q;
    logic [DW-1:0]  data_q;

    // Drive the bus from the current state.
    always_comb begin
        cur       = cur_q;
        bus_req   = (st_q != ENG_IDLE);
        bus_rd    = (st_q == ENG_READ);
        bus_wr    = (st_q == ENG_WRITE);
        beat      = bus_wr;
        bus_addr  = '0;
        bus_io    = 1'b0;
        bus_wdata = '0;
        if (st_q == ENG_READ) begin
            bus_addr = src_s;
            bus_io   = src_io_s;
        end else if (st_q == ENG_WRITE) begin
            bus_addr  = dst_s;
            bus_io    = dst_io_s;
            bus_wdata = data_q;
        end
    end

    // Sequence the tenure and latch the read byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ENG_IDLE;
            cur_q  <= '0;
            data_q <= '0;
        end else begin
            case (st_q)
                ENG_IDLE: begin
                    if (pend_any) begin
                        cur_q <= pick;
                        st_q  <= ENG_WAIT_GNT;
                    end
                end
                ENG_WAIT_GNT: begin
                    if (bus_gnt) begin
                        st_q <= ENG_READ;
                    end
                end
                ENG_READ: begin
                    data_q <= bus_rdata;
                    st_q   <= ENG_WRITE;
                end
                default: begin
                    if (last_s) begin
                        st_q <= ENG_IDLE;
                    end else begin
                        case (pace_s)
                            PACE_BURST: st_q <= ENG_READ;
                            PACE_STEAL: st_q <= ENG_IDLE;
                            default:    st_q <= cont_s ? ENG_READ : ENG_IDLE;
                        endcase
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/dma_xfer_ctrl.sv
// Top of the DMA transfer controller: NCH channels, a fixed-priority picker and
// one bus sequencer shared by all channels.
// Assumes: AW >= CW and AW >= the control word width; cfg_ch < NCH.
module dma_xfer_ctrl
    import dma_xfer_pkg::*;
#(
    parameter int NCH = 2,
    parameter int AW  = 20,
    parameter int IOW = 16,
    parameter int CW  = 16,
    parameter int DW  = 8,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_we,
    input  logic [CHW-1:0] cfg_ch,
    input  logic [1:0]     cfg_sel,
    input  logic [AW-1:0]  cfg_wdata,
    input  logic [NCH-1:0] dreq_n,
    output logic           bus_req,
    input  logic           bus_gnt,
    output logic           bus_rd,
    output logic           bus_wr,
    output logic           bus_io,
    output logic [AW-1:0]  bus_addr,
    input  logic [DW-1:0]  bus_rdata,
    output logic [DW-1:0]  bus_wdata,
    output logic [NCH-1:0] done
);
    logic [NCH-1:0]         pend_v;
    logic [NCH-1:0]         cont_v;
    logic [NCH-1:0]         last_v;
    logic [NCH-1:0]         sio_v;
    logic [NCH-1:0]         dio_v;
    logic [NCH-1:0]         adv_v;
    pace_e [NCH-1:0]        pace_v;
    logic [NCH-1:0][AW-1:0] src_v;
    logic [NCH-1:0][AW-1:0] dst_v;
    logic                   pend_any;
    logic [CHW-1:0]         pick;
    logic [CHW-1:0]         cur;
    logic                   beat;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        dma_xfer_chan #(.AW(AW), .IOW(IOW), .CW(CW)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .cfg_we    (cfg_we && (cfg_ch == CHW'(i))),
            .cfg_sel   (cfg_sel),
            .cfg_wdata (cfg_wdata),
            .dreq_n    (dreq_n[i]),
            .adv       (adv_v[i]),
            .pend      (pend_v[i]),
            .cont      (cont_v[i]),
            .last      (last_v[i]),
            .done      (done[i]),
            .pace      (pace_v[i]),
            .src_bus   (src_v[i]),
            .dst_bus   (dst_v[i]),
            .src_io    (sio_v[i]),
            .dst_io    (dio_v[i])
        );
        assign adv_v[i] = beat && (cur == CHW'(i));
    end

    dma_xfer_pick #(.NCH(NCH)) u_pick (
        .ready (pend_v),
        .any   (pend_any),
        .idx   (pick)
    );

    dma_xfer_engine #(.NCH(NCH), .AW(AW), .DW(DW)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .pend_any  (pend_any),
        .pick      (pick),
        .pace_s    (pace_v[cur]),
        .last_s    (last_v[cur]),
        .cont_s    (cont_v[cur]),
        .src_s     (src_v[cur]),
        .dst_s     (dst_v[cur]),
        .src_io_s  (sio_v[cur]),
        .dst_io_s  (dio_v[cur]),
        .bus_gnt   (bus_gnt),
        .bus_rdata (bus_rdata),
        .cur       (cur),
        .beat      (beat),
        .bus_req   (bus_req),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_io    (bus_io),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata)
    );
endmodule

// File: rtl/dma_xfer_ctrl_chk.sv
// Protocol checker for dma_xfer_ctrl, attached by bind below.
// Assumes: bus_gnt is held while bus_req is high once given.
module dma_xfer_ctrl_chk #(
    parameter int NCH = 2,
    parameter int AW  = 20,
    parameter int IOW = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_req,
    input logic              bus_gnt,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic              bus_io,
    input logic [AW-IOW-1:0] addr_hi,
    input logic [NCH-1:0]    done
);
    a_r2_wr_after_rd: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> bus_wr);
    a_r2_wr_needs_rd: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |-> $past(bus_rd));
    a_r2_rd_wr_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr));
    a_r11_gnt_in_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd || bus_wr) |-> (bus_req && bus_gnt));
    a_r11_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_gnt) |=> bus_req);
    a_r4_io_hi_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_rd || bus_wr) && bus_io) |-> (addr_hi == '0));
    a_r5_done_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(done));
    a_r5_done_after_wr: assert property (@(posedge clk) disable iff (!rst_n)
        (done != '0) |-> $past(bus_wr));
endmodule

bind dma_xfer_ctrl dma_xfer_ctrl_chk #(.NCH(NCH), .AW(AW), .IOW(IOW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .bus_req (bus_req),
    .bus_gnt (bus_gnt),
    .bus_rd  (bus_rd),
    .bus_wr  (bus_wr),
    .bus_io  (bus_io),
    .addr_hi (bus_addr[AW-1:IOW]),
    .done    (done)
);

// File: tb/dma_xfer_ctrl_tb_top.sv
// Bench: behavioural per-clock reference model plus directed scenarios.
module dma_xfer_ctrl_tb_top;
    localparam int LIMIT   = 190000;
    localparam int GNT_LAT = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic        cfg_ch = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [19:0] cfg_wdata = '0;
    logic [1:0]  dreq_n = 2'b11;
    logic        bus_req, bus_rd, bus_wr, bus_io;
    logic        bus_gnt = 1'b0;
    logic [19:0] bus_addr;
    logic [7:0]  bus_rdata, bus_wdata;
    logic [1:0]  done;

    int total = 0;
    int fails = 0;
    int cyc = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    function automatic logic [7:0] pat(input logic [19:0] a);
        return a[7:0] ^ a[15:8] ^ {4'h0, a[19:16]} ^ 8'h5A;
    endfunction

    assign bus_rdata = pat(bus_addr);

    dma_xfer_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .dreq_n(dreq_n), .bus_req(bus_req), .bus_gnt(bus_gnt),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_io(bus_io), .bus_addr(bus_addr),
        .bus_rdata(bus_rdata), .bus_wdata(bus_wdata), .done(done)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", total - fails, total);
    endtask

    // ---------------- reference model ----------------
    logic [19:0] m_src [2];
    logic [19:0] m_dst [2];
    logic [15:0] m_cnt [2];
    logic [9:0]  m_ctl [2];
    logic        m_flag [2];
    logic        m_prev [2];
    logic [1:0]  m_done;
    logic [7:0]  m_data;
    int          m_st, m_cur, nst;
    logic [1:0]  ed, pe, en_old;

    function automatic logic [19:0] emap(input logic [19:0] a, input logic io);
        return io ? {4'h0, a[15:0]} : a;
    endfunction

    function automatic logic [19:0] stp(input logic [19:0] a, input logic [1:0] s);
        if (s == 2'd0) return a + 20'd1;
        if (s == 2'd1) return a - 20'd1;
        return a;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 2; i++) begin
                m_src[i] = '0; m_dst[i] = '0; m_cnt[i] = '0; m_ctl[i] = '0;
                m_flag[i] = 1'b0; m_prev[i] = 1'b1;
            end
            m_done = '0; m_data = '0; m_st = 0; m_cur = 0;
        end else begin
            for (int i = 0; i < 2; i++) begin
                ed[i] = m_prev[i] & ~dreq_n[i];
                en_old[i] = m_ctl[i][0];
                pe[i] = m_ctl[i][0] && ((m_ctl[i][2:1] == 2'd1) || (m_ctl[i][2:1] == 2'd2) ||
                        (m_ctl[i][3] ? m_flag[i] : !dreq_n[i]));
            end
            nst = m_st;
            m_done = '0;
            case (m_st)
                0: if (pe != 2'b00) begin m_cur = pe[0] ? 0 : 1; nst = 1; end
                1: if (bus_gnt) nst = 2;
                2: begin m_data = pat(emap(m_src[m_cur], m_ctl[m_cur][8])); nst = 3; end
                default: begin
                    if (m_cnt[m_cur] == 16'd1) nst = 0;
                    else if (m_ctl[m_cur][2:1] == 2'd1) nst = 2;
                    else if (m_ctl[m_cur][2:1] == 2'd2) nst = 0;
                    else nst = (m_ctl[m_cur][3] ? ed[m_cur] : !dreq_n[m_cur]) ? 2 : 0;
                    m_src[m_cur] = stp(m_src[m_cur], m_ctl[m_cur][5:4]);
                    m_dst[m_cur] = stp(m_dst[m_cur], m_ctl[m_cur][7:6]);
                    if (m_cnt[m_cur] == 16'd1) begin
                        m_ctl[m_cur][0] = 1'b0;
                        m_done[m_cur] = 1'b1;
                    end
                    m_cnt[m_cur] = m_cnt[m_cur] - 16'd1;
                end
            endcase
            for (int i = 0; i < 2; i++) begin
                if (cfg_we && (int'(cfg_ch) == i) && (cfg_sel == 2'd3)) m_flag[i] = 1'b0;
                else if (en_old[i] && ed[i]) m_flag[i] = 1'b1;
                else if ((m_st == 3) && (m_cur == i)) m_flag[i] = 1'b0;
            end
            if (cfg_we) begin
                case (cfg_sel)
                    2'd0: m_src[cfg_ch] = cfg_wdata;
                    2'd1: m_dst[cfg_ch] = cfg_wdata;
                    2'd2: m_cnt[cfg_ch] = cfg_wdata[15:0];
                    default: m_ctl[cfg_ch] = cfg_wdata[9:0];
                endcase
            end
            for (int i = 0; i < 2; i++) m_prev[i] = dreq_n[i];
            m_st = nst;
        end
    end

    // ---------------- per-clock comparison and monitors ----------------
    int wr_n = 0, ten_n = 0;
    int done_n [2];
    logic [19:0] wr_log [$];
    logic [19:0] rd_log [$];
    logic req_d = 1'b0;
    logic [19:0] ea;
    logic eio;

    initial begin done_n[0] = 0; done_n[1] = 0; end

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk(bus_req == (m_st != 0), "R11 bus_req", bus_req, m_st != 0);
            chk(bus_rd == (m_st == 2), "R2 bus_rd", bus_rd, m_st == 2);
            chk(bus_wr == (m_st == 3), "R2 bus_wr", bus_wr, m_st == 3);
            if (m_st == 2 || m_st == 3) begin
                ea  = (m_st == 2) ? emap(m_src[m_cur], m_ctl[m_cur][8]) : emap(m_dst[m_cur], m_ctl[m_cur][9]);
                eio = (m_st == 2) ? m_ctl[m_cur][8] : m_ctl[m_cur][9];
                chk(bus_addr == ea, "R3 bus_addr", bus_addr, ea);
                chk(bus_io == eio, "R4 bus_io", bus_io, eio);
            end
            if (m_st == 3) chk(bus_wdata == m_data, "R2 bus_wdata", bus_wdata, m_data);
            chk(done == m_done, "R5 done", done, m_done);
            if (bus_wr) begin wr_n++; wr_log.push_back(bus_addr); end
            if (bus_rd) rd_log.push_back(bus_addr);
            if (bus_req && !req_d) ten_n++;
            req_d = bus_req;
            if (done[0]) done_n[0]++;
            if (done[1]) done_n[1]++;
        end
    end

    // Grant driver: answers a request after a fixed latency, drops with it.
    int lat = 0;
    always @(negedge clk) begin
        if (!bus_req) begin bus_gnt = 1'b0; lat = 0; end
        else if (lat >= GNT_LAT) bus_gnt = 1'b1;
        else lat++;
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc == LIMIT && !finished) begin
            finished = 1;
            total++; fails++;
            $display("FAIL watchdog actual=%0d expected<%0d", cyc, LIMIT);
            report();
            $finish;
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic step(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic wreg(input int ch, input int sel, input logic [19:0] d);
        cfg_we = 1'b1; cfg_ch = ch[0]; cfg_sel = sel[1:0]; cfg_wdata = d;
        step(1);
        cfg_we = 1'b0;
    endtask

    // R12 control word: bit0 enable, 2:1 pace, 3 edge, 5:4 src step, 7:6 dst step, 8 src io, 9 dst io
    function automatic logic [19:0] ctlw(input bit en, input int pace, input bit es, input int ss,
                                         input int ds, input bit sio, input bit dio);
        return {10'd0, dio, sio, ds[1:0], ss[1:0], es, pace[1:0], en};
    endfunction

    task automatic setup(input int ch, input logic [19:0] s, input logic [19:0] d, input logic [15:0] n);
        wreg(ch, 0, s);
        wreg(ch, 1, d);
        wreg(ch, 2, {4'h0, n});
    endtask

    task automatic wait_done(input int ch, input int target);
        while (done_n[ch] < target) step(1);
        step(2);
    endtask

    int w0, t0, l0, d0;

    initial begin
        step(4);
        // R1: reset state
        chk(bus_req == 1'b0 && bus_rd == 1'b0 && bus_wr == 1'b0, "R1 bus idle in reset",
            {bus_req, bus_rd, bus_wr}, 0);
        chk(done == 2'b00, "R1 done low in reset", done, 0);
        rst_n = 1'b1;
        step(2);
        chk(bus_req == 1'b0 && done == 2'b00, "R1 idle after reset", {bus_req, done}, 0);

        // R12: enable bit clear -> no request
        setup(0, 20'h00010, 20'h00020, 16'd5);
        wreg(0, 3, ctlw(0, 1, 0, 0, 0, 0, 0));
        w0 = wr_n; t0 = ten_n;
        step(15);
        chk(ten_n == t0 && wr_n == w0 && bus_req == 1'b0, "R12 disabled channel idle", ten_n - t0, 0);

        // R8 + R3: burst, src up across 64K, dst down across 64K
        setup(0, 20'h0FFFE, 20'h20000, 16'd4);
        w0 = wr_n; t0 = ten_n; l0 = wr_log.size(); d0 = done_n[0];
        wreg(0, 3, ctlw(1, 1, 0, 0, 1, 0, 0));
        wait_done(0, d0 + 1);
        chk(wr_n - w0 == 4, "R8 burst byte count", wr_n - w0, 4);
        chk(ten_n - t0 == 1, "R8 single tenure", ten_n - t0, 1);
        chk(rd_log[l0 + 2] == 20'h10000, "R3 carry into bit16", rd_log[l0 + 2], 20'h10000);
        chk(wr_log[l0 + 1] == 20'h1FFFF, "R3 borrow from bit16", wr_log[l0 + 1], 20'h1FFFF);
        chk(done_n[0] - d0 == 1, "R5 one done pulse", done_n[0] - d0, 1);

        // R9 + R4: cycle steal, memory fixed -> I/O counting up
        setup(1, 20'h12345, 20'hABCDE, 16'd3);
        w0 = wr_n; t0 = ten_n; l0 = wr_log.size(); d0 = done_n[1];
        wreg(1, 3, ctlw(1, 2, 0, 2, 0, 0, 1));
        wait_done(1, d0 + 1);
        chk(wr_n - w0 == 3, "R9 steal byte count", wr_n - w0, 3);
        chk(ten_n - t0 == 3, "R9 one tenure per byte", ten_n - t0, 3);
        chk(wr_log[l0] == 20'h0BCDE, "R4 io address upper zero", wr_log[l0], 20'h0BCDE);
        chk(wr_log[l0 + 2] == 20'h0BCE0, "R3 dst step up", wr_log[l0 + 2], 20'h0BCE0);

        // R6: level request, I/O -> memory
        dreq_n[0] = 1'b1;
        setup(0, 20'h3F00F, 20'h40000, 16'd10);
        w0 = wr_n; t0 = ten_n; d0 = done_n[0];
        wreg(0, 3, ctlw(1, 0, 0, 0, 0, 1, 0));
        step(20);
        chk(wr_n == w0 && ten_n == t0, "R6 quiet level blocks", wr_n - w0, 0);
        dreq_n[0] = 1'b0;
        wait_done(0, d0 + 1);
        dreq_n[0] = 1'b1;
        chk(wr_n - w0 == 10, "R6 level byte count", wr_n - w0, 10);
        chk(ten_n - t0 == 1, "R6 held level keeps bus", ten_n - t0, 1);

        // R7: edge request, I/O -> I/O
        dreq_n[1] = 1'b1;
        setup(1, 20'h0F0F0, 20'h00100, 16'd3);
        w0 = wr_n; d0 = done_n[1];
        wreg(1, 3, ctlw(1, 0, 1, 2, 0, 1, 1));
        step(2);
        dreq_n[1] = 1'b0;
        step(30);
        chk(wr_n - w0 == 1, "R7 held low gives one byte", wr_n - w0, 1);
        for (int k = 0; k < 2; k++) begin
            dreq_n[1] = 1'b1; step(3);
            dreq_n[1] = 1'b0; step(12);
        end
        wait_done(1, d0 + 1);
        dreq_n[1] = 1'b1;
        chk(wr_n - w0 == 3, "R7 one byte per edge", wr_n - w0, 3);

        // R10: both channels released together
        setup(0, 20'h00100, 20'h00200, 16'd2);
        setup(1, 20'h00300, 20'h00400, 16'd2);
        wreg(0, 3, ctlw(1, 0, 0, 0, 0, 0, 0));
        wreg(1, 3, ctlw(1, 0, 0, 0, 0, 0, 0));
        l0 = wr_log.size(); d0 = done_n[1];
        step(3);
        dreq_n = 2'b00;
        wait_done(1, d0 + 1);
        dreq_n = 2'b11;
        chk(wr_log[l0] == 20'h00200, "R10 channel 0 first", wr_log[l0], 20'h00200);
        chk(wr_log[l0 + 2] == 20'h00400, "R10 channel 1 after", wr_log[l0 + 2], 20'h00400);

        // R5: zero count means 65536 bytes
        setup(1, 20'h00000, 20'h80000, 16'd0);
        w0 = wr_n; d0 = done_n[1];
        wreg(1, 3, ctlw(1, 1, 0, 0, 0, 0, 0));
        wait_done(1, d0 + 1);
        chk(wr_n - w0 == 65536, "R5 zero count length", wr_n - w0, 65536);
        chk(done_n[1] - d0 == 1, "R5 single done", done_n[1] - d0, 1);
        step(10);
        chk(bus_req == 1'b0, "R5 channel disarmed", bus_req, 0);

        finished = 1;
        report();
        $finish;
    end
endmodule